// File: doc/BRIEF.md
# SPI Register Transaction Master with Wait-State Polling

This block performs a single register read or register write to a security-module style device over SPI, one byte at a time. A host hands it a request (direction, 24-bit register address, byte count minus one) through a valid/ready handshake. The block lowers chip select, which also wakes the device, and sends a four-byte frame header. It then polls single bytes until the device reports ready, moves the data bytes and raises chip select again. Completion is marked by a one-cycle `done` pulse.

The serial shifting is delegated to an external byte shifter. The block pulses `sh_go` with a byte on `sh_txd`. The shifter answers with a `sh_done` pulse carrying the received byte on `sh_rxd`. Write data is taken from `wr_data`, and `wr_next` pulses once for every byte consumed. Read data leaves on `rd_data`, qualified by `rd_valid`. If the device stalls for too many poll bytes, the transaction is abandoned with `err` raised alongside `done`.

Top module: `spi_reg_xact_master`

## Requirements
- R1: The first header byte sent is {bit7 = 1 for read / 0 for write, bit6 = 1, bits5:0 = req_len_m1}, where the byte count is req_len_m1 + 1 (1 to 64).
- R2: Header bytes two to four carry req_addr[23:16], req_addr[15:8] and req_addr[7:0] in that order.
- R3: cs_n goes low on the clock edge that accepts a request, together with the first sh_go, and stays low for every byte of the transaction.
- R4: After the four header bytes, the master sends poll bytes of 0x00 one at a time until a received poll byte has bit 0 equal to 1. At least one poll byte is always sent, and bits 7:1 of poll bytes are ignored.
- R5: Bytes received during the header and poll phases never appear on rd_valid/rd_data.
- R6: In a read, exactly req_len_m1 + 1 data bytes are sent as 0x00. Each received byte is presented on rd_data with a one-cycle rd_valid pulse, in order.
- R7: In a write, the data bytes sent are successive wr_data values, and wr_next pulses once per byte taken.
- R8: In the cycle after the final data byte's sh_done, cs_n is high and done pulses with err low.
- R9: If MAX_POLLS consecutive poll bytes are received not ready, no data phase occurs. The next cycle shows cs_n high and done and err both pulsing, after exactly 4 + MAX_POLLS bytes.
- R10: req_ready is high only while idle, and a request presented while busy is ignored.
- R11: Reset leaves cs_n high, req_ready high, and sh_go, done, err, rd_valid and wr_next low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid (idle only) |
| req_is_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 24 | Register address |
| req_len_m1 | input | 6 | Byte count minus one |
| wr_data | input | 8 | Current write byte |
| wr_next | output | 1 | Pulse: current write byte was taken |
| rd_valid | output | 1 | Pulse: rd_data holds a read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Pulse: transaction finished |
| err | output | 1 | Pulse with done: poll limit reached |
| cs_n | output | 1 | Active-low chip select |
| sh_go | output | 1 | Pulse: shift sh_txd out |
| sh_txd | output | 8 | Byte to transmit |
| sh_done | input | 1 | Pulse: shifter finished a byte |
| sh_rxd | input | 8 | Byte received, valid with sh_done |

## Verification
The first header byte and the low chip select appear on the edge that accepts the request. Every later byte launch, `rd_valid` pulse, `wr_next` pulse and the final `done`/`cs_n` release follows one clock after the `sh_done` that caused it. The bench drives and samples on the falling edge and stamps every `sh_done` with a cycle number. It requires `done` exactly one cycle after the last stamp and compares the full transmitted byte log afterwards. All lengths from 1 to 64 are swept in both directions with varied stall counts and shifter latencies, plus the poll-limit boundary on both sides.

// File: rtl/srtm_pkg.sv
// Shared constants and state type for the SPI register transaction master.
// Assumes the frame header length field is six bits wide (up to 64 bytes).
package srtm_pkg;
    localparam int LEN_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_POLL,
        ST_DATA
    } srtm_state_t;
endpackage

// File: rtl/srtm_hdr.sv
// Header byte selector: forms the direction/length byte followed by the
// address bytes, most significant first, and returns the one at index sel.
// Assumes sel never exceeds ADDR_BYTES.
module srtm_hdr
    import srtm_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int HDR_BYTES = ADDR_BYTES + 1,
    localparam int HIDX_W = $clog2(HDR_BYTES)
) (
    input  logic                    is_rd,
    input  logic [LEN_W-1:0]        len_m1,
    input  logic [8*ADDR_BYTES-1:0] addr,
    input  logic [HIDX_W-1:0]       sel,
    output logic [7:0]              hdr_byte
);
    logic [7:0] bytes [HDR_BYTES];

    // Byte 0: direction in bit 7, fixed one in bit 6, length minus one below.
    assign bytes[0] = {is_rd, 1'b1, len_m1};

    // Address bytes, most significant first.
    for (genvar k = 1; k < HDR_BYTES; k++) begin : g_addr
        assign bytes[k] = addr[8*(HDR_BYTES-1-k) +: 8];
    end

    // Select the requested header byte.
    assign hdr_byte = bytes[sel];
endmodule

// File: rtl/srtm_poll_cnt.sv
// Counts not-ready poll bytes of the current transaction and flags the
// last allowed one. Assumes MAX_POLLS >= 2 and that inc is never raised
// together with last.
module srtm_poll_cnt #(
    parameter int MAX_POLLS = 1024,
    localparam int CW = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt;

    // Count stalled polls; cleared whenever not polling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    // The next stalled poll would be the MAX_POLLS-th one.
    assign last = (cnt == CW'(MAX_POLLS - 1));

    p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_POLLS));
endmodule

// File: rtl/srtm_ctrl.sv
// Transaction sequencer: accepts a request while idle, then steps through
// the header, wait-poll and data phases one shifter byte at a time, and
// releases chip select at the end or on poll-limit failure.
// Assumes the shifter never raises sh_done in the cycle sh_go is high.
module srtm_ctrl
    import srtm_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int HDR_BYTES = ADDR_BYTES + 1,
    localparam int HIDX_W = $clog2(HDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_is_read,
    input  logic [8*ADDR_BYTES-1:0] req_addr,
    input  logic [LEN_W-1:0]        req_len_m1,
    input  logic [7:0]              wr_data,
    output logic                    wr_next,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    done,
    output logic                    err,
    output logic                    cs_n,
    output logic                    sh_go,
    output logic [7:0]              sh_txd,
    input  logic                    sh_done,
    input  logic [7:0]              sh_rxd,
    output logic                    h_is_rd,
    output logic [LEN_W-1:0]        h_len_m1,
    output logic [8*ADDR_BYTES-1:0] h_addr,
    output logic [HIDX_W-1:0]       h_sel,
    input  logic [7:0]              h_byte,
    output logic                    poll_clr,
    output logic                    poll_inc,
    input  logic                    poll_last
);
    srtm_state_t             st;
    logic                    is_rd_q;
    logic [LEN_W-1:0]        len_q;
    logic [8*ADDR_BYTES-1:0] addr_q;
    logic [LEN_W-1:0]        idx;

    // Header fields come from the request while idle, else from the latch.
    always_comb begin
        h_is_rd  = (st == ST_IDLE) ? req_is_read : is_rd_q;
        h_len_m1 = (st == ST_IDLE) ? req_len_m1  : len_q;
        h_addr   = (st == ST_IDLE) ? req_addr    : addr_q;
        h_sel    = (st == ST_IDLE) ? '0 : HIDX_W'(idx + 1'b1);
    end

    // Poll counter control: clear outside polling, count stalled polls.
    assign poll_clr  = (st != ST_POLL);
    assign poll_inc  = (st == ST_POLL) && sh_done && !sh_rxd[0] && !poll_last;
    assign req_ready = (st == ST_IDLE);

    // Main sequencer: one byte launched per shifter completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            is_rd_q  <= 1'b0;
            len_q    <= '0;
            addr_q   <= '0;
            idx      <= '0;
            cs_n     <= 1'b1;
            sh_go    <= 1'b0;
            sh_txd   <= 8'h00;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            done     <= 1'b0;
            err      <= 1'b0;
            wr_next  <= 1'b0;
        end else begin
            sh_go    <= 1'b0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            wr_next  <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    is_rd_q <= req_is_read;
                    len_q   <= req_len_m1;
                    addr_q  <= req_addr;
                    idx     <= '0;
                    cs_n    <= 1'b0;
                    sh_go   <= 1'b1;
                    sh_txd  <= h_byte;
                    st      <= ST_HDR;
                end
                ST_HDR: if (sh_done) begin
                    sh_go <= 1'b1;
                    if (idx == LEN_W'(HDR_BYTES - 1)) begin
                        sh_txd <= 8'h00;
                        st     <= ST_POLL;
                    end else begin
                        idx    <= idx + 1'b1;
                        sh_txd <= h_byte;
                    end
                end
                ST_POLL: if (sh_done) begin
                    if (sh_rxd[0]) begin
                        idx     <= '0;
                        sh_go   <= 1'b1;
                        sh_txd  <= is_rd_q ? 8'h00 : wr_data;
                        wr_next <= !is_rd_q;
                        st      <= ST_DATA;
                    end else if (poll_last) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                        err  <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        sh_go  <= 1'b1;
                        sh_txd <= 8'h00;
                    end
                end
                ST_DATA: if (sh_done) begin
                    if (is_rd_q) begin
                        rd_valid <= 1'b1;
                        rd_data  <= sh_rxd;
                    end
                    if (idx == len_q) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        idx     <= idx + 1'b1;
                        sh_go   <= 1'b1;
                        sh_txd  <= is_rd_q ? 8'h00 : wr_data;
                        wr_next <= !is_rd_q;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_cs_low_on_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_go |-> !cs_n);
    p_rd_only_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(st == ST_DATA && sh_done && is_rd_q));
    p_wr_next_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_next |-> (!is_rd_q && sh_go));
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sh_go));
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);
endmodule

// File: rtl/spi_reg_xact_master.sv
// Top level of the SPI register transaction master: ties the sequencer to
// the header selector and the poll-limit counter. Assumes one device and
// an external byte shifter that generates the serial clock.
module spi_reg_xact_master
    import srtm_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int MAX_POLLS  = 1024,
    localparam int HIDX_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_is_read,
    input  logic [8*ADDR_BYTES-1:0] req_addr,
    input  logic [LEN_W-1:0]        req_len_m1,
    input  logic [7:0]              wr_data,
    output logic                    wr_next,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    done,
    output logic                    err,
    output logic                    cs_n,
    output logic                    sh_go,
    output logic [7:0]              sh_txd,
    input  logic                    sh_done,
    input  logic [7:0]              sh_rxd
);
    logic                    h_is_rd;
    logic [LEN_W-1:0]        h_len_m1;
    logic [8*ADDR_BYTES-1:0] h_addr;
    logic [HIDX_W-1:0]       h_sel;
    logic [7:0]              h_byte;
    logic                    poll_clr, poll_inc, poll_last;

    srtm_hdr #(.ADDR_BYTES(ADDR_BYTES)) u_hdr (
        .is_rd(h_is_rd), .len_m1(h_len_m1), .addr(h_addr),
        .sel(h_sel), .hdr_byte(h_byte)
    );

    srtm_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
        .last(poll_last)
    );

    srtm_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_read(req_is_read), .req_addr(req_addr),
        .req_len_m1(req_len_m1), .wr_data(wr_data), .wr_next(wr_next),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .cs_n(cs_n), .sh_go(sh_go), .sh_txd(sh_txd),
        .sh_done(sh_done), .sh_rxd(sh_rxd),
        .h_is_rd(h_is_rd), .h_len_m1(h_len_m1), .h_addr(h_addr),
        .h_sel(h_sel), .h_byte(h_byte),
        .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last)
    );
endmodule

// File: tb/tb_spi_reg_xact_master.sv
`timescale 1ns/1ps
module tb_spi_reg_xact_master;
    localparam int NPOLL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_read = 1'b0;
    logic [23:0] req_addr = '0;
    logic [5:0] req_len_m1 = '0;
    logic [7:0] wr_data = 8'h00;
    logic sh_done = 1'b0;
    logic [7:0] sh_rxd = 8'h00;
    logic req_ready, wr_next, rd_valid, done, err, cs_n, sh_go;
    logic [7:0] rd_data, sh_txd;

    spi_reg_xact_master #(.MAX_POLLS(NPOLL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_read(req_is_read), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .wr_data(wr_data), .wr_next(wr_next), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .err(err), .cs_n(cs_n),
        .sh_go(sh_go), .sh_txd(sh_txd), .sh_done(sh_done), .sh_rxd(sh_rxd)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    logic [7:0] txlog [128];
    logic [7:0] rbuf [128];
    logic [7:0] wbuf [128];
    int ntx = 0, nrd = 0, widx = 0, cs_viol = 0, last_sd = 0;
    int cur_nw = 0, cur_lat = 0, cur_seed = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_pat(input int i, input int seed);
        return 8'((i * 29 + seed * 7 + 3) & 255);
    endfunction

    // Byte shifter model: answers each sh_go after cur_lat idle cycles.
    initial begin
        int delay = 0;
        bit pend = 0;
        int pos = 0;
        forever begin
            @(negedge clk);
            sh_done = 1'b0;
            if (sh_go) begin
                if (cs_n) cs_viol++;
                txlog[ntx] = sh_txd;
                pos = ntx;
                ntx++;
                delay = cur_lat;
                pend = 1;
            end
            if (pend && !sh_go || pend && cur_lat == 0 && sh_go) begin
                if (delay == 0 || (sh_go && cur_lat == 0)) begin
                    if (!sh_go || cur_lat == 0) begin
                        if (pos < 4) sh_rxd = 8'hFF;
                        else if (pos < 4 + cur_nw) sh_rxd = 8'hFE;
                        else if (pos == 4 + cur_nw) sh_rxd = 8'h01;
                        else sh_rxd = rd_pat(pos - 5 - cur_nw, cur_seed);
                        if (!(sh_go && cur_lat == 0)) begin
                            sh_done = 1'b1;
                            last_sd = cyc;
                            pend = 0;
                        end
                    end
                end else delay--;
            end
        end
    end

    // Read-data and write-data monitors.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rbuf[nrd] = rd_data;
                nrd++;
            end
            if (wr_next) begin
                widx++;
                wr_data = wbuf[widx];
            end
        end
    end

    task automatic run_xact(input bit rd, input int len, input logic [23:0] addr,
                            input int nw, input int lat, input bit intrude);
        bit expect_err;
        int total, got_done_cyc, t;
        bit seen_err;
        expect_err = (nw >= NPOLL);
        cur_nw = nw; cur_lat = lat; cur_seed = len + (rd ? 100 : 0);
        for (int i = 0; i < 128; i++) wbuf[i] = 8'((i * 13 + cur_seed) ^ 8'h5A);
        ntx = 0; nrd = 0; widx = 0; cs_viol = 0;
        wr_data = wbuf[0];
        @(negedge clk);
        req_valid = 1'b1; req_is_read = rd; req_addr = addr;
        req_len_m1 = 6'(len - 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!cs_n, "R3 cs_n low after accept", cs_n, 0);
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        if (intrude) begin
            req_valid = 1'b1; req_is_read = !rd; req_addr = ~addr; req_len_m1 = 6'h3F;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0; seen_err = 0; got_done_cyc = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        got_done_cyc = cyc; seen_err = err;
        chk(cs_n == 1'b1, "R8 cs_n high at done", cs_n, 1);
        chk(got_done_cyc == last_sd + 1, "R8 done one cycle after last sh_done",
            got_done_cyc, last_sd + 1);
        chk(seen_err == expect_err, "R9 err flag", seen_err, expect_err);
        chk(cs_viol == 0, "R3 cs_n low on every byte", cs_viol, 0);
        total = expect_err ? 4 + NPOLL : 5 + nw + len;
        chk(ntx == total, expect_err ? "R9 byte count" : "R4 byte count", ntx, total);
        chk(txlog[0] == {rd, 1'b1, 6'(len - 1)}, "R1 header byte0", txlog[0],
            {rd, 1'b1, 6'(len - 1)});
        chk(txlog[1] == addr[23:16], "R2 addr high", txlog[1], addr[23:16]);
        chk(txlog[2] == addr[15:8], "R2 addr mid", txlog[2], addr[15:8]);
        chk(txlog[3] == addr[7:0], "R2 addr low", txlog[3], addr[7:0]);
        for (int i = 4; i < ntx && i < (expect_err ? 4 + NPOLL : 5 + nw); i++)
            chk(txlog[i] == 8'h00, "R4 poll byte is zero", txlog[i], 0);
        if (expect_err) begin
            chk(nrd == 0, "R9 no read data", nrd, 0);
            chk(widx == 0, "R9 no write data", widx, 0);
        end else if (rd) begin
            chk(nrd == len, "R5 read byte count", nrd, len);
            for (int i = 0; i < len && i < nrd; i++)
                chk(rbuf[i] == rd_pat(i, cur_seed), "R6 read data", rbuf[i],
                    rd_pat(i, cur_seed));
            for (int i = 0; i < len; i++)
                chk(txlog[5 + nw + i] == 8'h00, "R6 read filler", txlog[5 + nw + i], 0);
        end else begin
            chk(nrd == 0, "R5 no read data in write", nrd, 0);
            chk(widx == len, "R7 wr_next count", widx, len);
            for (int i = 0; i < len; i++)
                chk(txlog[5 + nw + i] == wbuf[i], "R7 write data", txlog[5 + nw + i],
                    wbuf[i]);
        end
        if (intrude) begin
            repeat (4) @(negedge clk);
            chk(cs_n == 1'b1 && ntx == total, "R10 busy request ignored", ntx, total);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R11 reset cs_n", cs_n, 1);
        chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
        chk(!sh_go && !done && !err, "R11 reset go/done/err", {sh_go, done, err}, 0);
        chk(!rd_valid && !wr_next, "R11 reset rd_valid/wr_next", {rd_valid, wr_next}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int len = 1; len <= 64; len++) begin
            for (int rd = 0; rd < 2; rd++) begin
                run_xact(rd[0], len, 24'hD40000 ^ 24'(len * 24'h010307 + rd * 24'h800001),
                         (len + rd) % 4, len % 3, (len % 16) == 5);
            end
        end
        run_xact(1'b1, 10, 24'hD40018, NPOLL - 1, 1, 1'b0);
        run_xact(1'b0, 10, 24'hD40024, NPOLL - 1, 0, 1'b0);
        run_xact(1'b1, 10, 24'hD40F00, NPOLL, 1, 1'b0);
        run_xact(1'b0, 10, 24'hD40F04, NPOLL + 3, 2, 1'b0);
        run_xact(1'b1, 3, 24'h123456, 0, 0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule